// File: doc/BRIEF.md
# Delayed Lockstep Checker

This block runs two copies of a small tally unit, an accumulator with a sticky overflow flag, and checks that they behave identically. The main copy takes the block's command inputs directly and drives the block's data outputs. The shadow copy receives the same commands only after a fixed delay of `DLY` cycles. The main copy's observed vector is its accumulator, its overflow flag and its internal last-command register. That vector passes through a matching `DLY`-stage delay line, so it arrives in step with the shadow's vector. A radiation or supply event that hits both copies at the same moment therefore corrupts them at different points of the same computation.

Two independent comparators evaluate the aligned pair. If either comparator sees a difference, a sticky mismatch flag is raised. If the two comparators disagree with each other, a sticky latent-fault flag is raised as well. The block only reports faults and never corrects them. An injection control flips one chosen bit of the shadow-side vector for one cycle. The flip can be routed to both comparators, to test fault detection, or to the second comparator alone, to test the comparator cross-check.

Top module: `lockstep_guard`

## Requirements
- R1: Each cycle the main unit applies `cmd`: 0 keeps the accumulator, 1 adds one, 2 adds `dataIn`, 3 zeroes the accumulator and the overflow flag. The result appears on `accOut` after the next rising edge, and sums wrap modulo 2^W.
- R2: `ovfOut` goes high on any add that carries out of W bits. It then stays high until a `cmd` of 3.
- R3: While `rstN` is low, `accOut`, `ovfOut`, `mismatchErr` and `latentErr` are all 0.
- R4: The shadow unit runs the same commands `DLY` cycles late. It is compared with the delayed main vector, whose bit layout is: bits W-1..0 accumulator, bit W overflow, bits W+2..W+1 last command. Fault-free operation never raises either error flag.
- R5: For the first `DLY` rising edges after reset is released, comparison is masked. An injection in that window leaves both flags at 0.
- R6: `injPulse` high with `injLatent` low flips bit `injBit` of the shadow vector at both comparators. This raises `mismatchErr` after that edge and leaves `latentErr` at 0.
- R7: `injPulse` high with `injLatent` high flips the bit at the second comparator only. This raises both `mismatchErr` and `latentErr` after that edge.
- R8: Both flags hold until `errClr` is high at an edge, which clears them. A clear wins over a detection at the same edge.
- R9: An `injBit` value of W+3 or more flips nothing, and no flag is raised.
- R10: A raised flag does not alter `accOut` or `ovfOut`; the unit keeps computing as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command to the tally unit |
| dataIn | input | W (8) | Operand for the add command |
| injPulse | input | 1 | One-cycle injection request |
| injBit | input | clog2(W+3) (4) | Index of the bit to flip |
| injLatent | input | 1 | Route the flip to the second comparator only |
| errClr | input | 1 | Clear both sticky flags |
| accOut | output | W (8) | Main unit accumulator |
| ovfOut | output | 1 | Main unit overflow flag |
| mismatchErr | output | 1 | Sticky lockstep mismatch |
| latentErr | output | 1 | Sticky comparator disagreement |

## Verification
The hardest condition to reach from the ports is a disagreement between the two comparators. In a correct design they always see the same inputs, so only the second-comparator injection path can provoke it. The bench uses that path and checks that the latent flag rises together with the mismatch flag. The masked window is also narrow: it lasts only `DLY` edges. The bench therefore asserts injection on the very first cycles after reset release, then repeats it once the window has closed. Long stretches of mixed commands, including overflow, run between the injections to show that the staggered copies stay aligned.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_ADD  = 2'd2,
    OP_CLR  = 2'd3
  } tallyOp_e;

  typedef struct packed {
    logic cmpEn;
    logic injAll;
    logic injSecond;
  } guardStrb_t;
endpackage

// File: rtl/delay_line.sv
module delay_line #(
  parameter int WD = 8,
  parameter int N  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [WD-1:0] din,
  output logic [WD-1:0] dout
);
  logic [WD-1:0] stage [N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[N-1];
endmodule

// File: rtl/tally_unit.sv
module tally_unit
  import lsg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   cmd,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] accQ,
  output logic         ovfQ,
  output logic [1:0]   opQ
);
  logic [W:0] sum;

  always_comb begin
    case (cmd)
      OP_INC:  sum = {1'b0, accQ} + {{W{1'b0}}, 1'b1};
      OP_ADD:  sum = {1'b0, accQ} + {1'b0, dataIn};
      default: sum = {1'b0, accQ};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      ovfQ <= 1'b0;
      opQ  <= OP_HOLD;
    end else begin
      opQ <= cmd;
      if (cmd == OP_CLR) begin
        accQ <= '0;
        ovfQ <= 1'b0;
      end else begin
        accQ <= sum[W-1:0];
        ovfQ <= ovfQ | sum[W];
      end
    end
  end

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && cmd != OP_CLR) |=> ovfQ); // R2
endmodule

// File: rtl/lockstep_dp.sv
module lockstep_dp
  import lsg_pkg::*;
#(
  parameter int W    = 8,
  parameter int DLY  = 2,
  parameter int VW   = W + 3,
  parameter int SELW = $clog2(VW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      cmd,
  input  logic [W-1:0]    dataIn,
  input  guardStrb_t      strb,
  input  logic [SELW-1:0] injBit,
  output logic [W-1:0]    accOut,
  output logic            ovfOut,
  output logic [1:0]      diffRaw
);
  localparam int IW = W + 2;

  logic [W-1:0]  accM, accS;
  logic          ovfM, ovfS;
  logic [1:0]    opM, opS;
  logic [IW-1:0] inDly;
  logic [VW-1:0] mainVec, mainDly, shadowVec, injMask;

  tally_unit #(.W(W)) u_main (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dataIn(dataIn),
    .accQ(accM), .ovfQ(ovfM), .opQ(opM)
  );

  delay_line #(.WD(IW), .N(DLY)) u_inDly (
    .clk(clk), .rstN(rstN), .din({cmd, dataIn}), .dout(inDly)
  );

  tally_unit #(.W(W)) u_shadow (
    .clk(clk), .rstN(rstN), .cmd(inDly[IW-1:W]), .dataIn(inDly[W-1:0]),
    .accQ(accS), .ovfQ(ovfS), .opQ(opS)
  );

  assign mainVec   = {opM, ovfM, accM};
  assign shadowVec = {opS, ovfS, accS};

  delay_line #(.WD(VW), .N(DLY)) u_vecDly (
    .clk(clk), .rstN(rstN), .din(mainVec), .dout(mainDly)
  );

  assign injMask = VW'(1) << injBit;

  for (genvar k = 0; k < 2; k++) begin : g_cmp
    logic [VW-1:0] cmpIn;
    logic          flipHere;
    assign flipHere = strb.injAll | ((k == 1) && strb.injSecond);
    assign cmpIn    = shadowVec ^ (flipHere ? injMask : '0);
    assign diffRaw[k] = |(mainDly ^ cmpIn);
  end

  assign accOut = accM;
  assign ovfOut = ovfM;

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && !strb.injAll && !strb.injSecond) |-> (diffRaw == 2'b00)); // R4
endmodule

// File: rtl/lockstep_ctrl.sv
module lockstep_ctrl
  import lsg_pkg::*;
#(
  parameter int DLY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       injPulse,
  input  logic       injLatent,
  input  logic       errClr,
  input  logic [1:0] diffRaw,
  output guardStrb_t strb,
  output logic       mismatchErr,
  output logic       latentErr
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] ARMED_AT = CW'(DLY);

  logic [CW-1:0] warmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    warmCnt <= '0;
    else if (warmCnt != ARMED_AT) warmCnt <= warmCnt + 1'b1;
  end

  always_comb begin
    strb.cmpEn     = (warmCnt == ARMED_AT);
    strb.injAll    = injPulse & ~injLatent;
    strb.injSecond = injPulse & injLatent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mismatchErr <= 1'b0;
      latentErr   <= 1'b0;
    end else if (errClr) begin
      mismatchErr <= 1'b0;
      latentErr   <= 1'b0;
    end else if (strb.cmpEn) begin
      mismatchErr <= mismatchErr | diffRaw[0] | diffRaw[1];
      latentErr   <= latentErr | (diffRaw[0] ^ diffRaw[1]);
    end
  end

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cmpEn && !mismatchErr && !latentErr) |=> (!mismatchErr && !latentErr)); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchErr && !errClr) |=> mismatchErr); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> (!mismatchErr && !latentErr)); // R8
  AST_LATENT_WITH_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    latentErr |-> mismatchErr); // R7
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
  import lsg_pkg::*;
#(
  parameter int W    = 8,
  parameter int DLY  = 2,
  parameter int VW   = W + 3,
  parameter int SELW = $clog2(VW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      cmd,
  input  logic [W-1:0]    dataIn,
  input  logic            injPulse,
  input  logic [SELW-1:0] injBit,
  input  logic            injLatent,
  input  logic            errClr,
  output logic [W-1:0]    accOut,
  output logic            ovfOut,
  output logic            mismatchErr,
  output logic            latentErr
);
  guardStrb_t strb;
  logic [1:0] diffRaw;

  lockstep_ctrl #(.DLY(DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .injPulse(injPulse), .injLatent(injLatent),
    .errClr(errClr), .diffRaw(diffRaw), .strb(strb),
    .mismatchErr(mismatchErr), .latentErr(latentErr)
  );

  lockstep_dp #(.W(W), .DLY(DLY), .VW(VW), .SELW(SELW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dataIn(dataIn), .strb(strb),
    .injBit(injBit), .accOut(accOut), .ovfOut(ovfOut), .diffRaw(diffRaw)
  );
endmodule

// File: tb/lockstep_guard_tb.sv
module lockstep_guard_tb;
  localparam int W = 8;
  localparam int DLY = 2;
  localparam int VW = W + 3;
  localparam int SELW = $clog2(VW);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmd = '0;
  logic [W-1:0] dataIn = '0;
  logic injPulse = 1'b0;
  logic [SELW-1:0] injBit = '0;
  logic injLatent = 1'b0;
  logic errClr = 1'b0;
  logic [W-1:0] accOut;
  logic ovfOut, mismatchErr, latentErr;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  int mAcc = 0;
  bit mOvf = 1'b0;
  bit mMis = 1'b0;
  bit mLat = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  lockstep_guard #(.W(W), .DLY(DLY)) u_dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dataIn(dataIn), .injPulse(injPulse),
    .injBit(injBit), .injLatent(injLatent), .errClr(errClr),
    .accOut(accOut), .ovfOut(ovfOut), .mismatchErr(mismatchErr), .latentErr(latentErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check({tag, " accOut"}, int'(accOut), mAcc);
    check({tag, " ovfOut"}, int'(ovfOut), int'(mOvf));
    check({tag, " mismatchErr"}, int'(mismatchErr), int'(mMis));
    check({tag, " latentErr"}, int'(latentErr), int'(mLat));
  endtask

  task automatic step(input int c, input int d, input bit ij, input int ib,
                      input bit il, input bit clr, input string tag);
    int t;
    cmd = 2'(c); dataIn = W'(d); injPulse = ij; injBit = SELW'(ib);
    injLatent = il; errClr = clr;
    @(posedge clk);
    case (c)
      1: begin t = mAcc + 1; if (t >= (1 << W)) mOvf = 1'b1; mAcc = t % (1 << W); end
      2: begin t = mAcc + d; if (t >= (1 << W)) mOvf = 1'b1; mAcc = t % (1 << W); end
      3: begin mAcc = 0; mOvf = 1'b0; end
      default: ;
    endcase
    if (clr) begin
      mMis = 1'b0; mLat = 1'b0;
    end else if (cyc >= DLY && ij && ib < VW) begin
      mMis = 1'b1;
      if (il) mLat = 1'b1;
    end
    cyc++;
    @(negedge clk);
    compareAll(tag);
    injPulse = 1'b0; errClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R3 reset");
    rstN = 1'b1;
    // R5: inject during masked window, both routes
    step(1, 0, 1'b1, 2, 1'b0, 1'b0, "R5 mask");
    step(1, 0, 1'b1, 4, 1'b1, 1'b0, "R5 mask");
    // R1 R4: mixed traffic, no flags expected
    for (int i = 0; i < 300; i++) begin
      int c;
      c = (i * 7 + 3) % 4;
      if (i % 37 == 36) c = 3;
      step(c, (i * 53 + 17) % 256, 1'b0, 0, 1'b0, 1'b0, "R1 R4 traffic");
    end
    // R2: overflow and its persistence
    step(3, 0, 1'b0, 0, 1'b0, 1'b0, "R1 clear");
    step(2, 200, 1'b0, 0, 1'b0, 1'b0, "R1 add");
    step(2, 100, 1'b0, 0, 1'b0, 1'b0, "R2 carry");
    step(1, 0, 1'b0, 0, 1'b0, 1'b0, "R2 hold after inc");
    step(0, 0, 1'b0, 0, 1'b0, 1'b0, "R2 hold");
    step(2, 255, 1'b0, 0, 1'b0, 1'b0, "R2 second carry");
    step(3, 0, 1'b0, 0, 1'b0, 1'b0, "R2 clear");
    // R6: injection to both comparators
    step(1, 0, 1'b1, 3, 1'b0, 1'b0, "R6 inject acc bit");
    for (int i = 0; i < 10; i++) step(2, 30 + i, 1'b0, 0, 1'b0, 1'b0, "R10 R8 run after fault");
    // R8: clear wins over a simultaneous detection
    step(1, 0, 1'b1, 8, 1'b0, 1'b1, "R8 clear wins");
    step(0, 0, 1'b1, 10, 1'b0, 1'b0, "R6 inject op bit");
    step(0, 0, 1'b0, 0, 1'b0, 1'b1, "R8 clear");
    // R9: out of range index
    step(1, 0, 1'b1, 11, 1'b0, 1'b0, "R9 index 11");
    step(1, 0, 1'b1, 15, 1'b1, 1'b0, "R9 index 15");
    step(0, 0, 1'b0, 0, 1'b0, 1'b0, "R9 quiet");
    // R7: second comparator only
    step(2, 9, 1'b1, 0, 1'b1, 1'b0, "R7 latent inject");
    for (int i = 0; i < 5; i++) step(1, 0, 1'b0, 0, 1'b0, 1'b0, "R7 R10 hold");
    step(0, 0, 1'b0, 0, 1'b0, 1'b1, "R8 clear latent");
    step(1, 0, 1'b1, 9, 1'b1, 1'b0, "R7 latent ovf bit");
    step(0, 0, 1'b0, 0, 1'b0, 1'b0, "R7 held");
    // R3: reset in mid-run, then R5 again
    rstN = 1'b0;
    @(negedge clk);
    mAcc = 0; mOvf = 1'b0; mMis = 1'b0; mLat = 1'b0; cyc = 0;
    compareAll("R3 re-reset");
    rstN = 1'b1;
    step(1, 0, 1'b1, 1, 1'b0, 1'b0, "R5 mask again");
    step(1, 0, 1'b1, 1, 1'b0, 1'b0, "R5 mask again");
    step(1, 0, 1'b1, 1, 1'b0, 1'b0, "R5 first armed edge");
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule